// File: doc/BRIEF.md
# Dual-Edge Video Input Formatter

This block turns the two words captured per pixel-clock cycle from a 12-bit double-data-rate video bus (one word taken on the falling edge, one on the rising edge) into complete 24-bit pixels. The pixels come out as three 8-bit components plus a valid flag. A capture stage in the I/O ring samples the pins on both edges and hands the block both words together in one cycle. Colour-space conversion and sync handling are left to other stages.

A 2-bit format select chooses one of four packings:

- Full 8+8+8 on all twelve lines.
- 15-bit RGB (5+5+5) on the low eight lines.
- 16-bit RGB (5+6+5) on the low eight lines.
- 4:2:2 luma/chroma on the low eight lines. In this mode one pixel pair spreads over two clock cycles. The block emits two pixels that share the pair's chroma.

The format in force is latched only on a start pulse. The same pulse also realigns the 4:2:2 pair sequence.

Top module: `vfmt_unpack`

## Requirements
- R1: After reset `pixValid` is 0, all three components are 0 and the active packing is 8+8+8 (code 0).
- R2: Code 0 gives `pixR = riseWord[11:4]`, `pixG = {riseWord[3:0], fallWord[11:8]}` and `pixB = fallWord[7:0]`. The result appears one cycle after the input cycle.
- R3: Code 1 gives red from `riseWord[6:2]`, green from `{riseWord[1:0], fallWord[7:5]}` and blue from `fallWord[4:0]`. Each 5-bit field widens to 8 bits as `{f, f[4:2]}`. `riseWord[7]` and all bits above 7 are ignored.
- R4: Code 2 gives red from `riseWord[7:3]` (widened as in R3), green from `{riseWord[2:0], fallWord[7:5]}` widened as `{g, g[5:4]}`, and blue from `fallWord[4:0]` (widened as in R3).
- R5: Code 3 works on pairs of valid cycles. The first cycle carries Cb on `fallWord[7:0]` and Y0 on `riseWord[7:0]`. The second carries Cr on `fallWord[7:0]` and Y1 on `riseWord[7:0]`. The pixel (Y0, Cb, Cr) is output one cycle after the second cycle, and (Y1, Cb, Cr) the cycle after that. Cr appears on `pixR`, Y on `pixG` and Cb on `pixB`.
- R6: `pixValid` is high for exactly one cycle per pixel produced. Cycles with `inValid` low produce no pixel and do not advance the 4:2:2 pair position.
- R7: A change of `fmtSel` has no effect until a cycle with `startPulse` high. That cycle latches `fmtSel`, and its data produces no pixel.
- R8: After a start pulse, the first valid cycle in code 3 is taken as the Cb/Y0 cycle. A second pixel of a pair that has not yet been output is discarded.
- R9: While `pixValid` is low, the three components keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rstN | input | 1 | active-low asynchronous reset |
| inValid | input | 1 | both words of this cycle carry data |
| fallWord | input | 12 | word sampled on the falling edge |
| riseWord | input | 12 | word sampled on the rising edge |
| fmtSel | input | 2 | requested packing, latched on start |
| startPulse | input | 1 | latches format and realigns 4:2:2 pairs |
| pixValid | output | 1 | a new pixel is on the component outputs |
| pixR | output | 8 | red / Cr component |
| pixG | output | 8 | green / Y component |
| pixB | output | 8 | blue / Cb component |

## Verification
The bench builds the block with its default widths: a 12-bit bus and 8-bit components. These are the only widths at which all four packings are defined, so every field position and every widening rule can be reached. Random words on all twelve lines of both edges show that the unused high lines and the spare rising-edge bit never leak into a narrow packing. Irregular gaps in `inValid` during 4:2:2 traffic exercise back-to-back pairs, pairs split by idle cycles, and start pulses that land mid-pair or while a held pixel is still pending.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  localparam int BUS_W  = 12;
  localparam int COMP_W = 8;
  localparam int NARROW = 5;
  localparam int WIDEG  = 6;

  typedef enum logic [1:0] {
    FMT_FULL24 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_YC422  = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic direct;    // single-cycle packings: decode and load output
    logic capA;      // 4:2:2 first cycle: capture Cb and Y0
    logic emitPair;  // 4:2:2 second cycle: output first pixel, hold second
    logic emitHeld;  // output the held second pixel
  } strobe_t;

  function automatic logic [COMP_W-1:0] widen5(input logic [NARROW-1:0] v);
    return {v, v[NARROW-1 -: COMP_W-NARROW]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [WIDEG-1:0] v);
    return {v, v[WIDEG-1 -: COMP_W-WIDEG]};
  endfunction
endpackage

// File: rtl/vfmt_ctrl.sv
module vfmt_ctrl
  import vfmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] fmtSel,
  input  logic      startPulse,
  output strobe_t   strobe
);
  fmt_e fmtQ;
  logic phaseQ;
  logic pendQ;
  logic isPair;

  assign isPair = (fmtQ == FMT_YC422);

  always_comb begin
    strobe.fmt      = fmtQ;
    strobe.direct   = inValid && !startPulse && !isPair;
    strobe.capA     = inValid && !startPulse && isPair && !phaseQ;
    strobe.emitPair = inValid && !startPulse && isPair && phaseQ;
    strobe.emitHeld = pendQ && !startPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ   <= FMT_FULL24;
      phaseQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      pendQ <= strobe.emitPair;
      if (startPulse) begin
        fmtQ   <= fmt_e'(fmtSel);
        phaseQ <= 1'b0;
      end else if (inValid && isPair) begin
        phaseQ <= ~phaseQ;
      end
    end
  end

  // R7: packing only changes on a start cycle
  p_fmt_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(fmtQ));
  // R5: a held pixel never collides with a new pair completion
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> !strobe.emitPair);
  // R8: start discards any pending second pixel
  p_start_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !pendQ);
endmodule

// File: rtl/vfmt_datapath.sv
module vfmt_datapath
  import vfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BUS_W-1:0]  fallWord,
  input  logic [BUS_W-1:0]  riseWord,
  output logic              pixValid,
  output logic [COMP_W-1:0] pixR,
  output logic [COMP_W-1:0] pixG,
  output logic [COMP_W-1:0] pixB
);
  logic [COMP_W-1:0] decR, decG, decB;
  logic [COMP_W-1:0] capCb, capY0;
  logic [COMP_W-1:0] heldY1, heldCb, heldCr;
  logic anyLoad;

  assign anyLoad = strobe.direct || strobe.emitPair || strobe.emitHeld;

  always_comb begin
    decR = '0; decG = '0; decB = '0;
    unique case (strobe.fmt)
      FMT_FULL24: begin
        decR = riseWord[11:4];
        decG = {riseWord[3:0], fallWord[11:8]};
        decB = fallWord[7:0];
      end
      FMT_RGB555: begin
        decR = widen5(riseWord[6:2]);
        decG = widen5({riseWord[1:0], fallWord[7:5]});
        decB = widen5(fallWord[4:0]);
      end
      FMT_RGB565: begin
        decR = widen5(riseWord[7:3]);
        decG = widen6({riseWord[2:0], fallWord[7:5]});
        decB = widen5(fallWord[4:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixR <= '0; pixG <= '0; pixB <= '0;
      capCb <= '0; capY0 <= '0;
      heldY1 <= '0; heldCb <= '0; heldCr <= '0;
    end else begin
      pixValid <= anyLoad;
      if (strobe.capA) begin
        capCb <= fallWord[COMP_W-1:0];
        capY0 <= riseWord[COMP_W-1:0];
      end
      if (strobe.emitPair) begin
        pixR   <= fallWord[COMP_W-1:0];
        pixG   <= capY0;
        pixB   <= capCb;
        heldY1 <= riseWord[COMP_W-1:0];
        heldCb <= capCb;
        heldCr <= fallWord[COMP_W-1:0];
      end else if (strobe.emitHeld) begin
        pixR <= heldCr;
        pixG <= heldY1;
        pixB <= heldCb;
      end else if (strobe.direct) begin
        pixR <= decR;
        pixG <= decG;
        pixB <= decB;
      end
    end
  end

  // R6: every load strobe yields exactly one valid pixel next cycle
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> pixValid);
  p_valid_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> !pixValid);
  // R9: components hold when nothing is loaded
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> ($stable(pixR) && $stable(pixG) && $stable(pixB)));
endmodule

// File: rtl/vfmt_unpack.sv
module vfmt_unpack
  import vfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BUS_W-1:0]  fallWord,
  input  logic [BUS_W-1:0]  riseWord,
  input  logic [1:0]        fmtSel,
  input  logic              startPulse,
  output logic              pixValid,
  output logic [COMP_W-1:0] pixR,
  output logic [COMP_W-1:0] pixG,
  output logic [COMP_W-1:0] pixB
);
  strobe_t strobe;

  vfmt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel),
    .startPulse(startPulse), .strobe(strobe)
  );

  vfmt_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fallWord(fallWord),
    .riseWord(riseWord), .pixValid(pixValid), .pixR(pixR), .pixG(pixG),
    .pixB(pixB)
  );

  // R7: the start cycle itself never produces a pixel
  p_start_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !$past(strobe.emitPair)) |=> !pixValid);
endmodule

// File: tb/vfmt_unpack_tb_top.sv
module vfmt_unpack_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [11:0] fallWord = '0;
  logic [11:0] riseWord = '0;
  logic [1:0] fmtSel = '0;
  logic startPulse = 1'b0;
  logic pixValid;
  logic [7:0] pixR, pixG, pixB;

  int vectors = 0;
  int fails = 0;

  // reference model state
  int mFmt = 0;
  int mPhase = 0;
  logic [7:0] mCb = '0, mY0 = '0;
  logic [23:0] pq[$];
  logic eV = 1'b0;
  logic [7:0] eR = '0, eG = '0, eB = '0;

  always #5 clk = ~clk;

  vfmt_unpack dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fallWord(fallWord),
    .riseWord(riseWord), .fmtSel(fmtSel), .startPulse(startPulse),
    .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB)
  );

  function automatic logic [7:0] w5(input int v);
    return 8'((v << 3) | (v >> 2));
  endfunction
  function automatic logic [7:0] w6(input int v);
    return 8'((v << 2) | (v >> 4));
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (pixValid !== eV || pixR !== eR || pixG !== eG || pixB !== eB) begin
      fails++;
      $display("FAIL %s: got v=%0b R=%h G=%h B=%h, expected v=%0b R=%h G=%h B=%h",
               tag, pixValid, pixR, pixG, pixB, eV, eR, eG, eB);
    end
  endtask

  task automatic model(input logic [11:0] f, input logic [11:0] r, input logic v,
                       input logic [1:0] s, input logic st);
    logic [23:0] px;
    eV = 1'b0;
    if (st) begin
      mFmt = int'(s); mPhase = 0; pq.delete();
      return;
    end
    if (v && mFmt == 3) begin
      if (mPhase == 0) begin
        mCb = f[7:0]; mY0 = r[7:0];
      end else begin
        pq.push_back({f[7:0], mY0, mCb});
        pq.push_back({f[7:0], r[7:0], mCb});
      end
      mPhase = 1 - mPhase;
    end else if (v) begin
      eV = 1'b1;
      if (mFmt == 0) begin
        eR = r[11:4]; eG = {r[3:0], f[11:8]}; eB = f[7:0];
      end else if (mFmt == 1) begin
        eR = w5(int'(r[6:2])); eG = w5(int'({r[1:0], f[7:5]})); eB = w5(int'(f[4:0]));
      end else begin
        eR = w5(int'(r[7:3])); eG = w6(int'({r[2:0], f[7:5]})); eB = w5(int'(f[4:0]));
      end
    end
    if (pq.size() > 0) begin
      px = pq.pop_front();
      eV = 1'b1; eR = px[23:16]; eG = px[15:8]; eB = px[7:0];
    end
  endtask

  // called at a falling edge; applies one cycle and checks the result
  task automatic step(input logic [11:0] f, input logic [11:0] r, input logic v,
                      input logic [1:0] s, input logic st, input string tag);
    fallWord = f; riseWord = r; inValid = v; fmtSel = s; startPulse = st;
    @(posedge clk);
    model(f, r, v, s, st);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic burst(input int n, input logic [1:0] s, input int gapMod, input string tag);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = (gapMod == 0) ? 1'b1 : (($urandom % gapMod) != 0);
      step(12'($urandom), 12'($urandom), v, s, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no completion, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    // R1: default packing is 8+8+8 without any start pulse
    step(12'hABC, 12'h123, 1'b1, 2'd0, 1'b0, "R1");
    step(12'hFFF, 12'h000, 1'b1, 2'd0, 1'b0, "R2");
    step(12'h000, 12'hFFF, 1'b1, 2'd0, 1'b0, "R2");
    burst(40, 2'd0, 0, "R2");
    burst(40, 2'd0, 3, "R9");
    // R7: request another packing without start: must still decode as code 0
    burst(20, 2'd1, 0, "R7");
    step(12'h5A5, 12'hA5A, 1'b1, 2'd1, 1'b1, "R7");
    // R3: all ones on unused lines and the spare bit
    step(12'hF00, 12'h080, 1'b1, 2'd1, 1'b0, "R3");
    step(12'h01F, 12'h07C, 1'b1, 2'd1, 1'b0, "R3");
    burst(60, 2'd1, 4, "R3");
    step(12'h000, 12'h000, 1'b1, 2'd2, 1'b1, "R7");
    step(12'h0E0, 12'h007, 1'b1, 2'd2, 1'b0, "R4");
    step(12'h01F, 12'h0F8, 1'b1, 2'd2, 1'b0, "R4");
    burst(60, 2'd2, 4, "R4");
    step(12'h000, 12'h000, 1'b0, 2'd3, 1'b1, "R7");
    // R5: back-to-back pairs
    burst(40, 2'd3, 0, "R5");
    // R6: pairs split by idle cycles
    burst(80, 2'd3, 3, "R6");
    // R8: start right after a pair completes drops the held pixel
    step(12'h011, 12'h022, 1'b1, 2'd3, 1'b1, "R8");
    step(12'h0C1, 12'h0D2, 1'b1, 2'd3, 1'b0, "R8");
    step(12'h0C3, 12'h0D4, 1'b1, 2'd3, 1'b0, "R5");
    step(12'h000, 12'h000, 1'b0, 2'd3, 1'b1, "R8");
    // R8: start mid-pair realigns
    step(12'h0AA, 12'h0BB, 1'b1, 2'd3, 1'b0, "R8");
    step(12'h000, 12'h000, 1'b1, 2'd3, 1'b1, "R8");
    step(12'h031, 12'h041, 1'b1, 2'd3, 1'b0, "R8");
    step(12'h032, 12'h042, 1'b1, 2'd3, 1'b0, "R8");
    burst(10, 2'd3, 0, "R8");
    for (int k = 0; k < 6; k++) begin
      step(12'($urandom), 12'($urandom), 1'b1, 2'(k % 4), 1'b1, "R7");
      burst(30, 2'(k % 4), 3, "R6");
    end
    step(12'h000, 12'h000, 1'b0, 2'd0, 1'b1, "R7");
    burst(20, 2'd0, 2, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule